// File: doc/BRIEF.md
# Zero-Padded Block Correlation Sequencer

This block sits between a sampled up-link front end and an external transform path that correlates a long aperiodic spreading code by the frequency-domain method. On the sending side it frames the arriving complex samples into transform blocks of N entries. Each block holds N-L fresh samples and then L zeros. It stalls its input while the zeros go out. The zero tail lets a circular correlation stand in for the linear correlation of a code that never repeats within one block.

On the return side it takes the N correlation results of each block, one pair per valid strobe. Only bins 0 through L are free of wrap-around, so it keeps those and squares their magnitudes. It sums them non-coherently into one accumulator per bin over W consecutive blocks. After the W-th block it scans the L+1 sums for the largest one, the lowest bin winning a tie, and compares that value with a threshold. It then raises a one-cycle done pulse. On a hit the pulse carries the peak bin, which is the code offset in samples. On a miss the pulse comes with a request to move the local code on by L+1 phases before the next dwell.

Top module: `zp_corr_seq`

## Requirements
- R1: Every transform block on the tx port has exactly N valid beats: the N-L accepted input samples in arrival order, then L beats with tx_i = tx_q = 0. tx_last is high on beat N-1 (counting from 0) and low on all other beats.
- R2: in_ready is low for exactly L cycles after the (N-L)-th accepted sample of a block, and during those cycles one zero beat leaves per cycle with no gap.
- R3: Correlation beats are counted 0 to N-1 within a block. Only beats 0 to L contribute. Beats L+1 to N-1 have no effect on the decision or on peak_idx, and peak_idx never exceeds L.
- R4: Each kept bin accumulates cr_i*cr_i + cr_q*cr_q over the W blocks of a dwell. Sums start from zero at the first block of every dwell, so an earlier dwell has no influence on a later one.
- R5: Once the W-th block ends, peak_idx reports the bin with the largest sum. Among equal sums the lowest bin index is reported.
- R6: done pulses high for one cycle per dwell. hit is 1 on that cycle exactly when the largest sum is strictly greater than thr. A sum equal to thr is not a hit.
- R7: adv_req pulses, together with done, exactly on dwells where hit is 0. It is never high otherwise.
- R8: While reset is asserted, in_ready is 1 and tx_valid, done and adv_req are 0.
- R9: Sums are wide enough for W blocks of full-scale inputs (cr_i = cr_q = -2^(SW-1) in every block) without wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Fresh input sample present |
| in_i | input | SW | Input sample, in-phase, signed |
| in_q | input | SW | Input sample, quadrature, signed |
| in_ready | output | 1 | Input sample accepted this cycle when valid |
| tx_valid | output | 1 | Beat toward the transform path |
| tx_i | output | SW | Transform beat, in-phase |
| tx_q | output | SW | Transform beat, quadrature |
| tx_last | output | 1 | Final beat of a transform block |
| cr_valid | input | 1 | Correlation result beat present |
| cr_i | input | SW | Correlation result, in-phase, signed |
| cr_q | input | SW | Correlation result, quadrature, signed |
| thr | input | 2*SW+clog2(W) | Detection threshold, unsigned |
| done | output | 1 | One-cycle end-of-dwell pulse |
| hit | output | 1 | Acquisition flag, valid with done |
| peak_idx | output | clog2(L+1) | Peak bin, valid with done |
| adv_req | output | 1 | One-cycle request to shift the local code by L+1 phases |

## Verification
If the framing position counter goes out of step, the error appears within one block as a zero beat in the fresh region, a data beat in the tail, or a misplaced tx_last. If the correlation beat or block counters drift, the wrong bins are summed or the dwell ends at the wrong time. That shows up at the next done pulse as a wrong peak_idx or hit, or as a done pulse that comes too early or not at all. A bin that is not cleared or that wraps stays hidden until a later dwell or a full-scale dwell, where the decision against a threshold placed at the exact full-scale sum flips. The bench therefore runs dwells whose answers depend on the tail bins being dropped, on strict comparison at equality, on tie order, and on a clean start after a full-scale dwell.

// File: rtl/zp_pkg.sv
package zp_pkg;

  typedef enum logic {
    SR_IDLE = 1'b0,
    SR_SCAN = 1'b1
  } srch_state_e;

  function automatic int cnt_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/zp_framer.sv
module zp_framer #(
  parameter int N  = 64,
  parameter int L  = 40,
  parameter int SW = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [SW-1:0] in_i,
  input  logic signed [SW-1:0] in_q,
  output logic                 in_ready,
  output logic                 tx_valid,
  output logic signed [SW-1:0] tx_i,
  output logic signed [SW-1:0] tx_q,
  output logic                 tx_last
);

  localparam int PW = zp_pkg::cnt_bits(N);
  localparam logic [PW-1:0] FRESH_END = PW'(N - L);
  localparam logic [PW-1:0] POS_LAST  = PW'(N - 1);

  logic [PW-1:0]        pos_q, pos_d;
  logic                 step;
  logic                 vld_q;
  logic signed [SW-1:0] i_q, q_q, i_d, q_d;
  logic                 last_q, last_d;

  always_comb begin
    in_ready = (pos_q < FRESH_END);
    step     = in_ready ? in_valid : 1'b1;
    pos_d    = (pos_q == POS_LAST) ? '0 : pos_q + 1'b1;
    i_d      = in_ready ? in_i : '0;
    q_d      = in_ready ? in_q : '0;
    last_d   = (pos_q == POS_LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
    end else if (step) begin
      pos_q <= pos_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= step;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      i_q    <= '0;
      q_q    <= '0;
      last_q <= 1'b0;
    end else if (step) begin
      i_q    <= i_d;
      q_q    <= q_d;
      last_q <= last_d;
    end
  end

  assign tx_valid = vld_q;
  assign tx_i     = i_q;
  assign tx_q     = q_q;
  assign tx_last  = vld_q & last_q;

endmodule

// File: rtl/zp_accum.sv
module zp_accum #(
  parameter int N  = 64,
  parameter int L  = 40,
  parameter int W  = 4,
  parameter int SW = 12,
  parameter int AW = 26,
  parameter int IW = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cr_valid,
  input  logic signed [SW-1:0] cr_i,
  input  logic signed [SW-1:0] cr_q,
  input  logic                 hold,
  input  logic [IW-1:0]        rd_idx,
  output logic [AW-1:0]        rd_data,
  output logic                 dwell_end
);

  localparam int KW   = zp_pkg::cnt_bits(N);
  localparam int BW   = zp_pkg::cnt_bits(W);
  localparam int BINS = L + 1;
  localparam int MW   = 2 * SW;
  localparam logic [KW-1:0] K_LAST = KW'(N - 1);
  localparam logic [BW-1:0] B_LAST = BW'(W - 1);

  logic [KW-1:0]        k_q, k_d;
  logic [BW-1:0]        blk_q, blk_d;
  logic                 take;
  logic                 first_blk;
  logic                 end_d, end_q;
  logic signed [MW-1:0] sq_i, sq_q;
  logic [MW-1:0]        mag;
  logic [AW-1:0]        acc_w [BINS];

  always_comb begin
    take      = cr_valid & ~hold;
    first_blk = (blk_q == '0);
    sq_i      = MW'(cr_i) * MW'(cr_i);
    sq_q      = MW'(cr_q) * MW'(cr_q);
    mag       = sq_i + sq_q;
    k_d       = (k_q == K_LAST) ? '0 : k_q + 1'b1;
    blk_d     = blk_q;
    if (k_q == K_LAST) begin
      blk_d = (blk_q == B_LAST) ? '0 : blk_q + 1'b1;
    end
    end_d     = take & (k_q == K_LAST) & (blk_q == B_LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k_q   <= '0;
      blk_q <= '0;
    end else if (take) begin
      k_q   <= k_d;
      blk_q <= blk_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      end_q <= 1'b0;
    end else begin
      end_q <= end_d;
    end
  end

  for (genvar g = 0; g < BINS; g++) begin : g_bin
    logic          wr;
    logic [AW-1:0] val_q, val_d;

    always_comb begin
      wr    = take & (k_q == KW'(g));
      val_d = first_blk ? AW'(mag) : val_q + AW'(mag);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q <= '0;
      end else if (wr) begin
        val_q <= val_d;
      end
    end

    assign acc_w[g] = val_q;
  end

  assign rd_data   = acc_w[rd_idx];
  assign dwell_end = end_q;

endmodule

// File: rtl/zp_peak_search.sv
module zp_peak_search #(
  parameter int L  = 40,
  parameter int AW = 26,
  parameter int IW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] thr,
  input  logic [AW-1:0] rd_data,
  output logic [IW-1:0] rd_idx,
  output logic          busy,
  output logic          done,
  output logic          hit,
  output logic [IW-1:0] peak_idx,
  output logic          adv_req
);

  import zp_pkg::*;

  localparam logic [IW-1:0] IDX_LAST = IW'(L);

  srch_state_e   st_q, st_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [AW-1:0] best_q, best_d;
  logic [IW-1:0] bidx_q, bidx_d;
  logic          take_new;
  logic          fin;
  logic          over;
  logic          done_q, hit_q, adv_q;
  logic [IW-1:0] pk_q;

  always_comb begin
    take_new = (idx_q == '0) | (rd_data > best_q);
    best_d   = take_new ? rd_data : best_q;
    bidx_d   = take_new ? idx_q : bidx_q;
    fin      = (st_q == SR_SCAN) & (idx_q == IDX_LAST);
    over     = (best_d > thr);
    st_d     = st_q;
    idx_d    = idx_q;
    case (st_q)
      SR_IDLE: begin
        if (start) begin
          st_d  = SR_SCAN;
          idx_d = '0;
        end
      end
      SR_SCAN: begin
        if (fin) begin
          st_d = SR_IDLE;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      default: st_d = SR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SR_IDLE;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_q <= '0;
      bidx_q <= '0;
    end else if (st_q == SR_SCAN) begin
      best_q <= best_d;
      bidx_q <= bidx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      adv_q  <= 1'b0;
    end else begin
      done_q <= fin;
      adv_q  <= fin & ~over;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
      pk_q  <= '0;
    end else if (fin) begin
      hit_q <= over;
      pk_q  <= bidx_d;
    end
  end

  assign rd_idx   = idx_q;
  assign busy     = (st_q == SR_SCAN) | start;
  assign done     = done_q;
  assign hit      = hit_q;
  assign peak_idx = pk_q;
  assign adv_req  = adv_q;

endmodule

// File: rtl/zp_corr_seq.sv
module zp_corr_seq #(
  parameter int N  = 64,
  parameter int L  = 40,
  parameter int W  = 4,
  parameter int SW = 12,
  parameter int AW = 2 * SW + zp_pkg::cnt_bits(W),
  parameter int IW = zp_pkg::cnt_bits(L + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [SW-1:0] in_i,
  input  logic signed [SW-1:0] in_q,
  output logic                 in_ready,
  output logic                 tx_valid,
  output logic signed [SW-1:0] tx_i,
  output logic signed [SW-1:0] tx_q,
  output logic                 tx_last,
  input  logic                 cr_valid,
  input  logic signed [SW-1:0] cr_i,
  input  logic signed [SW-1:0] cr_q,
  input  logic [AW-1:0]        thr,
  output logic                 done,
  output logic                 hit,
  output logic [IW-1:0]        peak_idx,
  output logic                 adv_req
);

  logic [1:0]    rs_q;
  logic          rst_int_n;
  logic          hold;
  logic          dwell_end;
  logic [IW-1:0] rd_idx;
  logic [AW-1:0] rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= 2'b00;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end

  assign rst_int_n = rs_q[1];

  zp_framer #(.N(N), .L(L), .SW(SW)) i_framer (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .in_valid (in_valid),
    .in_i     (in_i),
    .in_q     (in_q),
    .in_ready (in_ready),
    .tx_valid (tx_valid),
    .tx_i     (tx_i),
    .tx_q     (tx_q),
    .tx_last  (tx_last)
  );

  zp_accum #(.N(N), .L(L), .W(W), .SW(SW), .AW(AW), .IW(IW)) i_accum (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cr_valid  (cr_valid),
    .cr_i      (cr_i),
    .cr_q      (cr_q),
    .hold      (hold),
    .rd_idx    (rd_idx),
    .rd_data   (rd_data),
    .dwell_end (dwell_end)
  );

  zp_peak_search #(.L(L), .AW(AW), .IW(IW)) i_search (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .start    (dwell_end),
    .thr      (thr),
    .rd_data  (rd_data),
    .rd_idx   (rd_idx),
    .busy     (hold),
    .done     (done),
    .hit      (hit),
    .peak_idx (peak_idx),
    .adv_req  (adv_req)
  );

endmodule

// File: rtl/zp_corr_seq_chk.sv
module zp_corr_seq_chk #(
  parameter int N  = 64,
  parameter int L  = 40,
  parameter int SW = 12,
  parameter int IW = 6
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 tx_valid,
  input logic signed [SW-1:0] tx_i,
  input logic signed [SW-1:0] tx_q,
  input logic                 tx_last,
  input logic                 done,
  input logic                 hit,
  input logic [IW-1:0]        peak_idx,
  input logic                 adv_req
);

  localparam int CW = zp_pkg::cnt_bits(N);

  logic [CW-1:0] beat_q;
  logic          in_tail;
  logic          tail_more;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q <= '0;
    end else if (tx_valid) begin
      beat_q <= (beat_q == CW'(N - 1)) ? '0 : beat_q + 1'b1;
    end
  end

  assign in_tail   = (beat_q >= CW'(N - L));
  assign tail_more = in_tail & (beat_q < CW'(N - 1));

  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && in_tail |-> (tx_i == '0) && (tx_q == '0)); // R1

  AST_LAST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_last == (beat_q == CW'(N - 1)))); // R1

  AST_PAD_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tail_more |=> tx_valid); // R2

  AST_PEAK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (peak_idx <= IW'(L))); // R3

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6

  AST_ADV_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    adv_req |-> done && !hit); // R7

  AST_MISS_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    done && !hit |-> adv_req); // R7

endmodule

bind zp_corr_seq zp_corr_seq_chk #(.N(N), .L(L), .SW(SW), .IW(IW)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tx_valid (tx_valid),
  .tx_i     (tx_i),
  .tx_q     (tx_q),
  .tx_last  (tx_last),
  .done     (done),
  .hit      (hit),
  .peak_idx (peak_idx),
  .adv_req  (adv_req)
);

// File: tb/test_zp_corr_seq.sv
`timescale 1ns/1ps
module test_zp_corr_seq;

  localparam int N  = 64;
  localparam int L  = 40;
  localparam int W  = 4;
  localparam int SW = 12;
  localparam int AW = 2 * SW + $clog2(W);
  localparam int IW = $clog2(L + 1);

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 in_valid = 1'b0;
  logic signed [SW-1:0] in_i = '0;
  logic signed [SW-1:0] in_q = '0;
  logic                 in_ready;
  logic                 tx_valid;
  logic signed [SW-1:0] tx_i;
  logic signed [SW-1:0] tx_q;
  logic                 tx_last;
  logic                 cr_valid = 1'b0;
  logic signed [SW-1:0] cr_i = '0;
  logic signed [SW-1:0] cr_q = '0;
  logic [AW-1:0]        thr = '0;
  logic                 done;
  logic                 hit;
  logic [IW-1:0]        peak_idx;
  logic                 adv_req;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  int tx_exp_i[$];
  int tx_exp_q[$];
  int tx_exp_l[$];
  int dw_exp_hit[$];
  int dw_exp_idx[$];

  always #10 clk = ~clk;

  zp_corr_seq #(.N(N), .L(L), .W(W), .SW(SW)) i_zp_corr_seq (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_i(in_i), .in_q(in_q), .in_ready(in_ready),
    .tx_valid(tx_valid), .tx_i(tx_i), .tx_q(tx_q), .tx_last(tx_last),
    .cr_valid(cr_valid), .cr_i(cr_i), .cr_q(cr_q), .thr(thr),
    .done(done), .hit(hit), .peak_idx(peak_idx), .adv_req(adv_req)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // tx monitor: scoreboard for framing (R1)
  always @(negedge clk) begin
    if (rst_n && tx_valid) begin
      if (tx_exp_i.size() == 0) begin
        check(0, "R1 unexpected tx beat", 1, 0);
      end else begin
        automatic int ei = tx_exp_i.pop_front();
        automatic int eq = tx_exp_q.pop_front();
        automatic int el = tx_exp_l.pop_front();
        check(int'(tx_i) == ei && int'(tx_q) == eq, "R1 tx data", longint'(tx_i), ei);
        check(int'(tx_last) == el, "R1 tx_last", longint'(tx_last), el);
      end
    end
  end

  // decision monitor (R5 R6 R7)
  always @(negedge clk) begin
    if (rst_n && (done || adv_req)) begin
      if (dw_exp_hit.size() == 0) begin
        check(0, "R6 unexpected done", longint'(done), 0);
      end else begin
        automatic int eh = dw_exp_hit.pop_front();
        automatic int ex = dw_exp_idx.pop_front();
        check(done == 1'b1, "R6 done with adv_req", longint'(done), 1);
        check(int'(hit) == eh, "R6 hit flag", longint'(hit), eh);
        check(int'(peak_idx) == ex, "R5 peak index", longint'(peak_idx), ex);
        check(int'(adv_req) == (1 - eh), "R7 adv_req", longint'(adv_req), 1 - eh);
      end
    end
  end

  task automatic run_frame(input int seed);
    int sent = 0;
    int low = 0;
    while (sent < N - L) begin
      @(negedge clk);
      if (in_ready && !((sent % 7) == 3 && in_valid)) begin
        automatic int vi = ((sent * 37 + seed) % 4000) - 2000;
        automatic int vq = ((sent * 53 + seed * 3) % 3000) - 1500;
        in_valid = 1'b1;
        in_i = SW'(vi);
        in_q = SW'(vq);
        tx_exp_i.push_back(vi);
        tx_exp_q.push_back(vq);
        tx_exp_l.push_back(0);
        sent++;
      end else begin
        in_valid = 1'b0;
      end
    end
    for (int z = 0; z < L; z++) begin
      tx_exp_i.push_back(0);
      tx_exp_q.push_back(0);
      tx_exp_l.push_back(z == L - 1 ? 1 : 0);
    end
    @(negedge clk);
    in_valid = 1'b0;
    while (!in_ready) begin
      low++;
      @(negedge clk);
    end
    check(low == L, "R2 in_ready low cycles", low, L);
    repeat (3) @(negedge clk);
    check(tx_exp_i.size() == 0, "R2 pad beats emitted", tx_exp_i.size(), 0);
  endtask

  function automatic int gen_i(input int p, input int b, input int k);
    int n = ((k * 7 + b * 13 + p * 5) % 9) - 4;
    case (p)
      0: return (k == 17) ? 200 : n;
      1: return (k == 50) ? 2000 : n;
      2: return (k == 9 || k == 30) ? 100 : 0;
      3, 4: return (k == L) ? -2048 : 0;
      default: return n;
    endcase
  endfunction

  function automatic int gen_q(input int p, input int b, input int k);
    int n = ((k * 11 + b * 3 + p) % 7) - 3;
    case (p)
      0: return (k == 17) ? -150 : n;
      1: return (k == 50) ? 2000 : n;
      2: return 0;
      3, 4: return (k == L) ? -2048 : 0;
      default: return n;
    endcase
  endfunction

  task automatic run_dwell(input int p, input longint t, input string req);
    longint sums [L+1];
    longint best = 0;
    int bi = 0;
    for (int k = 0; k <= L; k++) sums[k] = 0;
    for (int b = 0; b < W; b++)
      for (int k = 0; k <= L; k++) begin
        automatic longint vi = gen_i(p, b, k);
        automatic longint vq = gen_q(p, b, k);
        sums[k] += vi * vi + vq * vq;
      end
    for (int k = 0; k <= L; k++)
      if (k == 0 || sums[k] > best) begin
        best = sums[k];
        bi = k;
      end
    dw_exp_hit.push_back(best > t ? 1 : 0);
    dw_exp_idx.push_back(bi);
    thr = AW'(t);
    for (int b = 0; b < W; b++)
      for (int k = 0; k < N; k++) begin
        @(negedge clk);
        if (k == 3) begin
          cr_valid = 1'b0;
          @(negedge clk);
        end
        cr_valid = 1'b1;
        cr_i = SW'(gen_i(p, b, k));
        cr_q = SW'(gen_q(p, b, k));
      end
    @(negedge clk);
    cr_valid = 1'b0;
    while (dw_exp_hit.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    check(1, req, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(in_ready == 1'b1, "R8 in_ready in reset", longint'(in_ready), 1);
    check(tx_valid == 1'b0, "R8 tx_valid in reset", longint'(tx_valid), 0);
    check(done == 1'b0 && adv_req == 1'b0, "R8 done/adv in reset", longint'({done, adv_req}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run_frame(11);   // R1 R2
    run_frame(517);  // R1 R2
    run_dwell(0, 100000, "R4 peak dwell");
    run_dwell(1, 500, "R3 tail bins dropped");
    run_dwell(2, 0, "R5 tie lowest");
    run_dwell(3, (longint'(1) << 25) - 1, "R9 full scale hit");
    run_dwell(4, longint'(1) << 25, "R6 equal not hit");
    run_dwell(5, 90, "R4 cleared after full scale");
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule